// File: doc/BRIEF.md
# Fixed-Frequency Chopping Current Regulator

This block closes the digital side of a constant-current loop for one unipolar winding pair. A divider on the system clock marks the start of every chopping period with a one-clock pulse. That pulse sets an on-latch, and the latch drives the gate of whichever half of the pair is selected. An external current comparator reports, as a single logic level, that the sensed current has reached its reference. Once a short blanking window after turn-on has passed, that report clears the latch. The gate then stays off until the next period begins. Because the chopping rate is locked to the system clock, the two halves of a motor never beat against each other while the motor holds position.

The selected half of the pair can change at any time. When it does, both gates are held off for a programmable dead interval before the new half may conduct. An enable input blanks both gates at once. While enable is low, the divider, latch and phase tracking are all frozen in their idle state.

Top module: `chop_pwm_top`

## Requirements
- R1: While `rst_n` is low, both `gate_pos` and `gate_neg` are low.
- R2: While `en` is high, `period_start` is high for exactly one clock out of every `DIV` clocks (default 18).
- R3: In the clock after a `period_start` clock, the gate of the selected half is high unless a dead interval is running.
- R4: A `cur_trip` level seen during the `BLANK` clocks after a `period_start` clock (default 2) has no effect, and the gate stays high.
- R5: A `cur_trip` level seen once blanking is over drives the gate low from the next clock. The gate then stays low until the clock after the next `period_start`, even if `cur_trip` falls again.
- R6: If `cur_trip` is already high when blanking ends, the gate is high for exactly `BLANK`+1 clocks of that period.
- R7: With no trip, the gate stays high for all `DIV` clocks from the clock after one `period_start` through the next `period_start` clock.
- R8: `gate_pos` and `gate_neg` are never high in the same clock.
- R9: After `phase_sel` changes, both gates are low for exactly `DEAD` clocks (default 3), counted from the clock after the change is sampled. Only then may the newly selected gate go high.
- R10: While `en` is low, both gates and `period_start` are low, and `phase_sel` and `cur_trip` are ignored. In the first clock with `en` high again, `period_start` is high.
- R11: `phase_sel` = 0 selects `gate_pos`, and `phase_sel` = 1 selects `gate_neg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Drive enable; low blanks both gates and freezes the block |
| phase_sel | input | 1 | Selects the conducting half: 0 positive, 1 negative |
| cur_trip | input | 1 | Comparator result: high when the sensed current has reached the reference |
| period_start | output | 1 | One-clock marker at the start of each chopping period |
| gate_pos | output | 1 | Gate drive for the positive half |
| gate_neg | output | 1 | Gate drive for the negative half |

## Verification
A corrupted on-latch or blanking counter shows up as a wrong number of high gate clocks in the period where it happens. So a modelled current ramp that stops the gate at a known clock exposes it within one chopping period. A divider fault stretches or shrinks the spacing of `period_start` and is caught at the next marker. A broken dead-interval counter appears only when the phase changes. There it shows either as an early rise of the new gate or as an overlap with the old one, within `DEAD`+1 clocks of the change.

// File: rtl/chop_pkg.sv
// Shared types for the chopping regulator.
package chop_pkg;
    // Which half of the winding pair conducts.
    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_e;
endpackage

// File: rtl/chop_period_gen.sv
// Period divider: counts system clocks and emits a one-clock start marker
// every DIV clocks. Assumes DIV >= 2. Held at count zero while disabled, so
// a new period begins in the first enabled clock.
module chop_period_gen #(
    parameter int unsigned DIV = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic set_pulse
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running modulo-DIV counter, parked at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign set_pulse = en && (cnt == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
    AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse); // R2
endmodule

// File: rtl/chop_latch.sv
// On-latch with leading-edge blanking. A start marker sets the latch and
// loads the blanking counter. The trip input is ignored while the counter
// runs and clears the latch afterwards. Assumes the trip input is already
// synchronous to clk. At most one on-interval per period.
module chop_latch #(
    parameter int unsigned BLANK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_pulse,
    input  logic trip,
    output logic on_q
);
    localparam int unsigned BW = (BLANK > 0) ? $clog2(BLANK + 1) : 1;

    logic [BW-1:0] bcnt;

    // Set on the marker, count down blanking, then honour the trip.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            on_q <= 1'b0;
            bcnt <= '0;
        end else if (set_pulse) begin
            on_q <= 1'b1;
            bcnt <= BW'(BLANK);
        end else if (bcnt != '0) begin
            bcnt <= bcnt - 1'b1;
        end else if (trip) begin
            on_q <= 1'b0;
        end
    end

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && on_q && bcnt != '0) |=> on_q); // R4
    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && on_q && bcnt == '0 && trip && !set_pulse) |=> !on_q); // R5
    AST_STAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !set_pulse) |=> !on_q); // R5
endmodule

// File: rtl/chop_deadband.sv
// Phase steering with dead interval. Tracks the selected half. On a change
// it blanks both gates for DEAD clocks before the new half may conduct.
// Assumes DEAD >= 1. Frozen while disabled, so selection changes made
// then take effect only after enable returns.
module chop_deadband
    import chop_pkg::*;
#(
    parameter int unsigned DEAD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic phase_sel,
    input  logic drive,
    output logic gate_pos,
    output logic gate_neg
);
    localparam int unsigned DW = (DEAD > 0) ? $clog2(DEAD + 1) : 1;

    phase_e        cur;
    logic [DW-1:0] dcnt;
    logic          live;

    // Follow the requested half and run the dead counter on each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= PH_POS;
            dcnt <= '0;
        end else if (en) begin
            if (phase_e'(phase_sel) != cur) begin
                cur  <= phase_e'(phase_sel);
                dcnt <= DW'(DEAD);
            end else if (dcnt != '0) begin
                dcnt <= dcnt - 1'b1;
            end
        end
    end

    assign live     = en && drive && (dcnt == '0);
    assign gate_pos = live && (cur == PH_POS);
    assign gate_neg = live && (cur == PH_NEG);

    AST_NO_SWAP_P: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pos |=> !gate_neg); // R9
    AST_NO_SWAP_N: assert property (@(posedge clk) disable iff (!rst_n)
        gate_neg |=> !gate_pos); // R9
    AST_DEAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_sel != cur) |=> (!gate_pos && !gate_neg)); // R9
endmodule

// File: rtl/chop_pwm_top.sv
// Fixed-frequency chopping regulator for one winding pair: period divider,
// blanked on-latch and dead-interval steering. Assumes cur_trip is
// synchronous to clk and reset is held for at least one clock.
module chop_pwm_top #(
    parameter int unsigned DIV   = 18,
    parameter int unsigned BLANK = 2,
    parameter int unsigned DEAD  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic phase_sel,
    input  logic cur_trip,
    output logic period_start,
    output logic gate_pos,
    output logic gate_neg
);
    logic set_pulse;
    logic on_q;

    chop_period_gen #(.DIV(DIV)) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .set_pulse (set_pulse)
    );

    chop_latch #(.BLANK(BLANK)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .set_pulse (set_pulse),
        .trip      (cur_trip),
        .on_q      (on_q)
    );

    chop_deadband #(.DEAD(DEAD)) u_dead (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .phase_sel (phase_sel),
        .drive     (on_q),
        .gate_pos  (gate_pos),
        .gate_neg  (gate_neg)
    );

    assign period_start = set_pulse;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pos && gate_neg)); // R8
    AST_EN_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!gate_pos && !gate_neg && !period_start)); // R10
    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (!gate_pos && !gate_neg)); // R1
endmodule

// File: tb/sim_chop_pwm_top.sv
// Scoreboard bench: a driver task queues per-period trip profiles together
// with the expected on-time derived from a modelled current ramp. A monitor
// runs the profiles and compares the measured on-time at each period marker.
module sim_chop_pwm_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 18;
    localparam int BLANK = 2;
    localparam int DEAD  = 3;

    typedef struct {
        int t;
        bit pulse;
    } stim_t;
    typedef struct {
        int    on;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic phase_sel = 1'b0;
    logic cur_trip;
    logic manual_trip = 1'b0;
    logic period_start, gate_pos, gate_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    stim_t stim_q[$];
    exp_t  exp_q[$];
    bit    auto_on = 1'b0;
    bit    in_win = 1'b0;
    stim_t cur;
    int    pos, on_cnt, win_len;
    bit    auto_trip = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chop_pwm_top #(.DIV(DIV), .BLANK(BLANK), .DEAD(DEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .phase_sel(phase_sel),
        .cur_trip(cur_trip), .period_start(period_start),
        .gate_pos(gate_pos), .gate_neg(gate_neg)
    );

    assign cur_trip = auto_on ? auto_trip : manual_trip;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: current ramps by slope per on-clock; trip holds once it reaches lvl.
    task automatic push_ramp(input int lvl, input int slope, input string tag);
        stim_t s;
        exp_t  e;
        s.t = (lvl + slope - 1) / slope;
        s.pulse = 1'b0;
        if (s.t >= DIV) e.on = DIV;
        else e.on = (s.t > BLANK + 1) ? s.t : BLANK + 1;
        e.tag = tag;
        stim_q.push_back(s);
        exp_q.push_back(e);
    endtask

    // Driver: single-clock trip glitch at period position t.
    task automatic push_pulse(input int t, input string tag);
        stim_t s;
        exp_t  e;
        s.t = t;
        s.pulse = 1'b1;
        e.on = (t <= BLANK) ? DIV : t;
        e.tag = tag;
        stim_q.push_back(s);
        exp_q.push_back(e);
    endtask

    // Monitor: measure positive-gate on-time per period and drive the trip profile.
    always @(negedge clk) begin
        if (auto_on) begin
            if (period_start) begin
                if (in_win) begin
                    exp_t e;
                    on_cnt += int'(gate_pos);
                    win_len++;
                    e = exp_q.pop_front();
                    chk({e.tag, " on-time"}, on_cnt, e.on);
                    chk("R2 period length", win_len, DIV);
                    in_win = 1'b0;
                end
                if (stim_q.size() > 0) begin
                    cur = stim_q.pop_front();
                    in_win = 1'b1;
                    pos = 0;
                    on_cnt = 0;
                    win_len = 0;
                end
            end else if (in_win) begin
                pos++;
                on_cnt += int'(gate_pos);
                win_len++;
            end
            auto_trip = in_win && (cur.pulse ? (pos == cur.t) : (pos >= cur.t));
        end else begin
            auto_trip = 1'b0;
        end
    end

    // R8 exclusion and R9 minimum gap between opposite halves.
    int last_on = 0;
    int off_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (gate_pos && gate_neg) begin
                errors++;
                $display("FAIL R8 overlap actual=1 expected=0");
            end
            if (gate_pos) begin
                if (last_on == 2) chk("R9 gap before positive", int'(off_run >= DEAD), 1);
                last_on = 1;
                off_run = 0;
            end else if (gate_neg) begin
                if (last_on == 1) chk("R9 gap before negative", int'(off_run >= DEAD), 1);
                last_on = 2;
                off_run = 0;
            end else begin
                off_run++;
            end
        end
    end

    initial begin
        // R1: reset blanks both gates
        repeat (3) @(negedge clk);
        chk("R1 gate_pos in reset", int'(gate_pos), 0);
        chk("R1 gate_neg in reset", int'(gate_neg), 0);

        push_ramp(10, 1, "R5 ramp trip at 10");
        push_ramp(1, 4, "R6 early trip");
        push_ramp(0, 1, "R6 trip from start");
        push_ramp(60, 2, "R7 no trip");
        push_pulse(2, "R4 glitch in blanking");
        push_pulse(1, "R4 glitch at first clock");
        push_pulse(6, "R5 glitch latches off");
        push_ramp(51, 3, "R5 trip at last clock");
        push_ramp(9, 3, "R6 trip at blanking end");
        push_ramp(99, 1, "R3 full period");
        auto_on = 1'b1;
        rst_n = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        auto_on = 1'b0;

        // R9 / R11: swap to the negative half while the latch is on
        @(negedge clk);
        chk("R11 sel 0 drives gate_pos", int'(gate_pos), 1);
        chk("R11 sel 0 keeps gate_neg low", int'(gate_neg), 0);
        phase_sel = 1'b1;
        for (int k = 0; k < DEAD; k++) begin
            @(negedge clk);
            chk("R9 dead interval both low", int'(gate_pos || gate_neg), 0);
        end
        @(negedge clk);
        chk("R9 new half after dead interval", int'(gate_neg), 1);
        chk("R11 sel 1 keeps gate_pos low", int'(gate_pos), 0);

        // R10: disable blanks outputs and ignores inputs
        en = 1'b0;
        #1;
        chk("R10 gates off when disabled", int'(gate_pos || gate_neg), 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            manual_trip = k[0];
            phase_sel = (k < 3) ? 1'b0 : 1'b1;
            chk("R10 no period marker while disabled", int'(period_start), 0);
            chk("R10 gates stay off while disabled", int'(gate_pos || gate_neg), 0);
        end
        @(negedge clk);
        manual_trip = 1'b0;
        en = 1'b1;
        #1;
        chk("R10 period restarts on enable", int'(period_start), 1);
        @(negedge clk);
        chk("R3 gate on after restart, no dead interval", int'(gate_neg), 1);
        chk("R2 marker lasts one clock", int'(period_start), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule